// File: doc/BRIEF.md
# Clause 37 Autonegotiation Sequencer

This block runs Clause 37 link autonegotiation for a PCS that operates either as 1000BASE-X or as SGMII. It owns the negotiation control register (enable, restart, soft reset, forced duplex, speed select). It decides when a negotiation starts or starts again. It builds the 16-bit configuration word for the transmit path and watches the configuration words that the receive path has already decoded. When the base pages have been exchanged, it captures the partner's page, records completion and resolves duplex.

The transmitted word has three layouts. In 1000BASE-X the advertisement word is sent as given. On the SGMII MAC side a fixed word is sent. On the SGMII PHY side the word carries link, duplex and speed, and a select input picks whether those fields come from register values or from side-band pins. Each negotiation opens with a silent phase of all-zero words. A loss of receive sync also forces a restart. Both of these times are parameters in clock cycles, with one value for 1000BASE-X and one for SGMII.

Top module: `an37_seq`

## Requirements
- R1: The control register (`ctrl_q`) resets to 0x0140 with bit 12 (negotiation enable) equal to parameter AN_EN_RST. A write with bit 15 set restores the reset value. Bits 15 and 9 never read back as 1.
- R2: A restart begins a silent phase in which `tx_cfg` is 0. Restart sources are reset, a soft reset (bit 15), a write with bit 9 set while enabled, and a rise of the enable bit.
- R3: After reset the silent phase lasts BRK_X_CYC cycles in 1000BASE-X and BRK_S_CYC cycles in SGMII, within two cycles. After it, the block's own word is sent.
- R4: Receive sync held low for SYNC_X_CYC cycles (1000BASE-X) or SYNC_S_CYC cycles (SGMII) restarts negotiation. A shorter loss has no effect.
- R5: In 1000BASE-X, `tx_cfg` equals `adv_word`, with bit 14 (ACK) cleared before the base page is received and set afterwards.
- R6: On the SGMII MAC side (`phy_side`=0), `tx_cfg` is 0x4001 outside the silent phase.
- R7: On the SGMII PHY side, `tx_cfg` has bit 15 = link, bit 14 = 1, bit 12 = duplex, bits 11:10 = speed, bit 0 = 1 and all other bits 0. With `pin_src`=0 the fields come from `anc_link`, `adv_word[5]` and {ctrl bit 6, ctrl bit 13}. With `pin_src`=1 they come from `sb_link`, `sb_fdx` and `sb_speed`.
- R8: The partner's base page counts as received after MATCH_N consecutive identical nonzero words, compared with bit 14 ignored. An all-zero word clears the count.
- R9: After the base page is received, the block sends its word with ACK. It completes after MATCH_N consecutive words that carry ACK and match the captured page. Completion comes only from this acknowledge phase.
- R10: On completion, `an_done` sets, and `lp_page` takes the partner page with bit 14 cleared. In SGMII, `lp_fdx` takes partner bit 12 and `lp_speed` takes partner bits 11:10. `an_done` holds until a `sts_clr` pulse. `an_irq` is high only while `an_done` and `anc_irq_en` are both high.
- R11: With negotiation enabled, `res_fdx` is the partner's duplex captured at completion: bit 5 in 1000BASE-X, bit 12 in SGMII. With negotiation disabled, `res_fdx` follows ctrl bit 8.
- R12: With negotiation disabled, `tx_cfg` is 0 and received words do not complete a negotiation.
- R13: A `rx_err` pulse outside the silent phase restarts negotiation. In the completed state, a received word that differs from the captured page (bit 14 ignored) also restarts negotiation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sgmii_en | input | 1 | 1 = SGMII, 0 = 1000BASE-X |
| phy_side | input | 1 | SGMII role: 1 = PHY side, 0 = MAC side |
| pin_src | input | 1 | PHY side: 1 = fields from pins, 0 = from registers |
| ctrl_wr | input | 1 | Control register write strobe |
| ctrl_wdata | input | 16 | Control register write data |
| ctrl_q | output | 16 | Control register contents |
| adv_word | input | 16 | Advertisement word |
| anc_link | input | 1 | Register link status for the PHY side |
| anc_irq_en | input | 1 | Interrupt enable |
| sb_link | input | 1 | Side-band link pin |
| sb_fdx | input | 1 | Side-band duplex pin |
| sb_speed | input | 2 | Side-band speed pins |
| rx_cfg | input | 16 | Received configuration word |
| rx_cfg_vld | input | 1 | rx_cfg is valid this cycle |
| rx_sync | input | 1 | Receive code-group sync |
| rx_err | input | 1 | Error while receiving /C/ or /I/ |
| sts_clr | input | 1 | Write-one-to-clear strobe for completion status |
| tx_cfg | output | 16 | Configuration word to transmit |
| an_done | output | 1 | Completion status |
| an_irq | output | 1 | Completion interrupt |
| lp_page | output | 16 | Captured partner page, ACK cleared |
| lp_fdx | output | 1 | Partner duplex (SGMII) |
| lp_speed | output | 2 | Partner speed (SGMII) |
| res_fdx | output | 1 | Resolved duplex |

## Verification
`tx_cfg` is combinational from the phase register. It therefore changes in the cycle after the edge that samples the qualifying word or control write. `an_done`, the captured partner fields and `res_fdx` change on that same edge. The bench drives at the falling edge and leaves an idle cycle between received words. It samples two or three cycles after the last stimulus, so every result is already settled. Silent-phase and sync-loss lengths are measured by counting falling edges. These counts are compared against a window around the parameter, or against inputs held deliberately two cycles short of or past the threshold.

// File: rtl/cl37_pkg.sv
package cl37_pkg;
   typedef enum logic [2:0] {
      ST_DIS   = 3'd0,
      ST_BREAK = 3'd1,
      ST_ABIL  = 3'd2,
      ST_ACK   = 3'd3,
      ST_DONE  = 3'd4
   } an_state_t;

   localparam int CFG_W      = 16;
   localparam int ACK_B      = 14;
   localparam int CTL_SRST_B = 15;
   localparam int CTL_SPD1_B = 13;
   localparam int CTL_EN_B   = 12;
   localparam int CTL_RSTRT_B = 9;
   localparam int CTL_DPX_B  = 8;
   localparam int CTL_SPD0_B = 6;
   localparam int ADV_FD_B   = 5;
endpackage

// File: rtl/cl37_timer.sv
module cl37_timer #(
   parameter int TW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clr,
   input  logic          run,
   input  logic [TW-1:0] limit,
   output logic          done
);
   logic [TW-1:0] cnt_q;

   assign done = (cnt_q >= limit);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt_q <= '0;
      else if (clr)
         cnt_q <= '0;
      else if (run && !done)
         cnt_q <= cnt_q + 1'b1;
   end
endmodule

// File: rtl/cl37_page_match.sv
module cl37_page_match #(
   parameter int W     = 16,
   parameter int ACK_B = 14,
   parameter int N     = 3
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr,
   input  logic         rearm,
   input  logic         vld,
   input  logic [W-1:0] word,
   input  logic         ack_req,
   output logic         hit,
   output logic [W-1:0] page
);
   localparam int CW = $clog2(N + 1);
   localparam logic [W-1:0] ACK_MASK = ~(W'(1) << ACK_B);

   logic [W-1:0]  prev_q;
   logic [CW-1:0] cnt_q;
   logic [W-1:0]  masked;
   logic          ack_ok;

   assign masked = word & ACK_MASK;
   assign ack_ok = !ack_req || word[ACK_B];
   assign hit    = (cnt_q == CW'(N));
   assign page   = prev_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_q <= '0;
         cnt_q  <= '0;
      end else if (clr) begin
         prev_q <= '0;
         cnt_q  <= '0;
      end else if (rearm) begin
         cnt_q  <= '0;
      end else if (vld) begin
         if (masked == '0) begin
            prev_q <= '0;
            cnt_q  <= '0;
         end else if (masked == prev_q) begin
            if (ack_ok && !hit)
               cnt_q <= cnt_q + 1'b1;
         end else begin
            prev_q <= masked;
            cnt_q  <= ack_ok ? CW'(1) : '0;
         end
      end
   end
endmodule

// File: rtl/cl37_tx_word.sv
module cl37_tx_word #(
   parameter int  W       = 16,
   parameter int  ACK_B   = 14,
   parameter bit  SB_PINS = 1'b1
) (
   input  logic         sgmii_en,
   input  logic         phy_side,
   input  logic         pin_src,
   input  logic         send,
   input  logic         ack,
   input  logic [W-1:0] adv,
   input  logic         reg_link,
   input  logic         reg_fdx,
   input  logic [1:0]   reg_spd,
   input  logic         pin_link,
   input  logic         pin_fdx,
   input  logic [1:0]   pin_spd,
   output logic [W-1:0] word
);
   logic       use_pin;
   logic       f_link;
   logic       f_fdx;
   logic [1:0] f_spd;
   logic [W-1:0] x_word;
   logic [W-1:0] mac_word;
   logic [W-1:0] phy_word;

   generate
      if (SB_PINS) begin : g_pins
         assign use_pin = pin_src;
      end else begin : g_nopins
         assign use_pin = 1'b0;
      end
   endgenerate

   assign f_link = use_pin ? pin_link : reg_link;
   assign f_fdx  = use_pin ? pin_fdx  : reg_fdx;
   assign f_spd  = use_pin ? pin_spd  : reg_spd;

   always_comb begin
      x_word        = adv;
      x_word[ACK_B] = ack;
      mac_word      = '0;
      mac_word[ACK_B] = 1'b1;
      mac_word[0]   = 1'b1;
      phy_word      = '0;
      phy_word[15]  = f_link;
      phy_word[ACK_B] = 1'b1;
      phy_word[12]  = f_fdx;
      phy_word[11:10] = f_spd;
      phy_word[0]   = 1'b1;
      if (!send)
         word = '0;
      else if (!sgmii_en)
         word = x_word;
      else if (phy_side)
         word = phy_word;
      else
         word = mac_word;
   end
endmodule

// File: rtl/an37_seq.sv
module an37_seq #(
   parameter bit AN_EN_RST  = 1'b1,
   parameter int BRK_X_CYC  = 1250000,
   parameter int BRK_S_CYC  = 200000,
   parameter int SYNC_X_CYC = 1250000,
   parameter int SYNC_S_CYC = 200000,
   parameter int MATCH_N    = 3,
   parameter bit SB_PINS    = 1'b1,
   parameter bit IRQ_FLOP   = 1'b0
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        sgmii_en,
   input  logic        phy_side,
   input  logic        pin_src,
   input  logic        ctrl_wr,
   input  logic [15:0] ctrl_wdata,
   output logic [15:0] ctrl_q,
   input  logic [15:0] adv_word,
   input  logic        anc_link,
   input  logic        anc_irq_en,
   input  logic        sb_link,
   input  logic        sb_fdx,
   input  logic [1:0]  sb_speed,
   input  logic [15:0] rx_cfg,
   input  logic        rx_cfg_vld,
   input  logic        rx_sync,
   input  logic        rx_err,
   input  logic        sts_clr,
   output logic [15:0] tx_cfg,
   output logic        an_done,
   output logic        an_irq,
   output logic [15:0] lp_page,
   output logic        lp_fdx,
   output logic [1:0]  lp_speed,
   output logic        res_fdx
);
   import cl37_pkg::*;

   localparam int BRK_MAX  = (BRK_X_CYC > BRK_S_CYC) ? BRK_X_CYC : BRK_S_CYC;
   localparam int SYN_MAX  = (SYNC_X_CYC > SYNC_S_CYC) ? SYNC_X_CYC : SYNC_S_CYC;
   localparam int TMAX     = (BRK_MAX > SYN_MAX) ? BRK_MAX : SYN_MAX;
   localparam int TW       = $clog2(TMAX + 1);
   localparam logic [15:0] CTRL_RST = 16'h0140 | (AN_EN_RST ? 16'h1000 : 16'h0000);
   localparam logic [15:0] CTRL_RO0 = (16'(1) << CTL_SRST_B) | (16'(1) << CTL_RSTRT_B);
   localparam logic [15:0] ACK_MASK = ~(16'(1) << ACK_B);

   generate
      if (MATCH_N < 2) begin : g_bad_match
         $error("MATCH_N must be at least 2");
      end
      if (BRK_X_CYC < 1 || BRK_S_CYC < 1 || SYNC_X_CYC < 1 || SYNC_S_CYC < 1) begin : g_bad_tmr
         $error("timer limits must be at least 1");
      end
   endgenerate

   an_state_t   state_q, state_d;
   logic        an_en;
   logic        soft_w, rstrt_w, restart, brk_enter;
   logic        brk_done, sync_to, m_hit;
   logic [15:0] m_page;
   logic [TW-1:0] brk_lim, sync_lim;
   logic        rx_active, partner_new;
   logic        done_q, lp_fdx_q, fdx_q;
   logic [1:0]  lp_spd_q;
   logic [15:0] lp_page_q;

   // control register
   assign soft_w  = ctrl_wr && ctrl_wdata[CTL_SRST_B];
   assign rstrt_w = ctrl_wr && !ctrl_wdata[CTL_SRST_B] && ctrl_wdata[CTL_RSTRT_B];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         ctrl_q <= CTRL_RST;
      else if (soft_w)
         ctrl_q <= CTRL_RST;
      else if (ctrl_wr)
         ctrl_q <= ctrl_wdata & ~CTRL_RO0;
   end

   assign an_en = ctrl_q[CTL_EN_B];

   // timers
   assign brk_lim  = sgmii_en ? TW'(BRK_S_CYC)  : TW'(BRK_X_CYC);
   assign sync_lim = sgmii_en ? TW'(SYNC_S_CYC) : TW'(SYNC_X_CYC);

   cl37_timer #(.TW(TW)) u_brk_tmr (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (brk_enter),
      .run   (state_q == ST_BREAK),
      .limit (brk_lim),
      .done  (brk_done)
   );

   cl37_timer #(.TW(TW)) u_sync_tmr (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (rx_sync || (state_q == ST_DIS) || sync_to),
      .run   (1'b1),
      .limit (sync_lim),
      .done  (sync_to)
   );

   // base page matcher
   cl37_page_match #(.W(CFG_W), .ACK_B(ACK_B), .N(MATCH_N)) u_match (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr     ((state_q == ST_DIS) || (state_q == ST_BREAK)),
      .rearm   ((state_q == ST_ABIL) && m_hit),
      .vld     (rx_cfg_vld && ((state_q == ST_ABIL) || (state_q == ST_ACK))),
      .word    (rx_cfg),
      .ack_req (state_q == ST_ACK),
      .hit     (m_hit),
      .page    (m_page)
   );

   // restart sources
   assign rx_active   = (state_q == ST_ABIL) || (state_q == ST_ACK) || (state_q == ST_DONE);
   assign partner_new = (state_q == ST_DONE) && rx_cfg_vld && ((rx_cfg & ACK_MASK) != lp_page_q);
   assign restart     = soft_w || rstrt_w || sync_to || (rx_err && rx_active) || partner_new;

   always_comb begin
      state_d = state_q;
      if (!an_en)
         state_d = ST_DIS;
      else if (restart)
         state_d = ST_BREAK;
      else begin
         case (state_q)
            ST_DIS:   state_d = ST_BREAK;
            ST_BREAK: if (brk_done) state_d = ST_ABIL;
            ST_ABIL:  if (m_hit)    state_d = ST_ACK;
            ST_ACK:   if (m_hit)    state_d = ST_DONE;
            ST_DONE:  state_d = ST_DONE;
            default:  state_d = ST_DIS;
         endcase
      end
   end

   assign brk_enter = (state_d == ST_BREAK) && ((state_q != ST_BREAK) || restart);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         state_q <= AN_EN_RST ? ST_BREAK : ST_DIS;
      else
         state_q <= state_d;
   end

   // completion capture and status
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         done_q    <= 1'b0;
         lp_page_q <= '0;
         lp_fdx_q  <= 1'b0;
         lp_spd_q  <= '0;
         fdx_q     <= 1'b0;
      end else if ((state_q == ST_ACK) && (state_d == ST_DONE)) begin
         done_q    <= 1'b1;
         lp_page_q <= m_page;
         lp_fdx_q  <= sgmii_en ? m_page[12] : 1'b0;
         lp_spd_q  <= sgmii_en ? m_page[11:10] : 2'b00;
         fdx_q     <= sgmii_en ? m_page[12] : m_page[ADV_FD_B];
      end else if (sts_clr) begin
         done_q    <= 1'b0;
      end
   end

   generate
      if (IRQ_FLOP) begin : g_irq_ff
         logic irq_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) irq_q <= 1'b0;
            else        irq_q <= done_q && anc_irq_en;
         end
         assign an_irq = irq_q;
      end else begin : g_irq_comb
         assign an_irq = done_q && anc_irq_en;
      end
   endgenerate

   assign an_done  = done_q;
   assign lp_page  = lp_page_q;
   assign lp_fdx   = lp_fdx_q;
   assign lp_speed = lp_spd_q;
   assign res_fdx  = an_en ? fdx_q : ctrl_q[CTL_DPX_B];

   // transmit word
   cl37_tx_word #(.W(CFG_W), .ACK_B(ACK_B), .SB_PINS(SB_PINS)) u_txw (
      .sgmii_en (sgmii_en),
      .phy_side (phy_side),
      .pin_src  (pin_src),
      .send     (rx_active),
      .ack      ((state_q == ST_ACK) || (state_q == ST_DONE)),
      .adv      (adv_word),
      .reg_link (anc_link),
      .reg_fdx  (adv_word[ADV_FD_B]),
      .reg_spd  ({ctrl_q[CTL_SPD0_B], ctrl_q[CTL_SPD1_B]}),
      .pin_link (sb_link),
      .pin_fdx  (sb_fdx),
      .pin_spd  (sb_speed),
      .word     (tx_cfg)
   );
endmodule

// File: rtl/cl37_seq_chk.sv
module cl37_seq_chk (
   input logic        clk,
   input logic        rst_n,
   input logic        sgmii_en,
   input logic        phy_side,
   input logic [2:0]  state,
   input logic        ctrl_en,
   input logic [15:0] tx_cfg,
   input logic        an_done,
   input logic        sts_clr
);
   import cl37_pkg::*;

   p_break_silent_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (state == 3'(ST_BREAK)) |-> (tx_cfg == 16'h0000));

   p_x_noack_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (!sgmii_en && state == 3'(ST_ABIL)) |-> !tx_cfg[14]);

   p_x_ack_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (!sgmii_en && state == 3'(ST_ACK)) |-> tx_cfg[14]);

   p_mac_word_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (sgmii_en && !phy_side && (state == 3'(ST_ABIL) || state == 3'(ST_ACK) || state == 3'(ST_DONE)))
      |-> (tx_cfg == 16'h4001));

   p_done_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (an_done && !sts_clr) |=> an_done);

   p_done_origin_r9: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(an_done) |-> ($past(state) == 3'(ST_ACK)));

   p_disabled_r12: assert property (@(posedge clk) disable iff (!rst_n)
      !ctrl_en |=> (state == 3'(ST_DIS)));
endmodule

bind an37_seq cl37_seq_chk u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .sgmii_en (sgmii_en),
   .phy_side (phy_side),
   .state    (state_q),
   .ctrl_en  (ctrl_q[12]),
   .tx_cfg   (tx_cfg),
   .an_done  (an_done),
   .sts_clr  (sts_clr)
);

// File: tb/an37_seq_tb.sv
module an37_seq_tb;
   localparam int CLK_PER = 10;
   localparam int BRK_X = 40;
   localparam int BRK_S = 16;
   localparam int SYN_X = 30;
   localparam int SYN_S = 12;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        sgmii_en = 1'b0, phy_side = 1'b0, pin_src = 1'b0;
   logic        ctrl_wr = 1'b0;
   logic [15:0] ctrl_wdata = '0;
   logic [15:0] ctrl_q;
   logic [15:0] adv_word = 16'h01A0;
   logic        anc_link = 1'b1, anc_irq_en = 1'b1;
   logic        sb_link = 1'b0, sb_fdx = 1'b0;
   logic [1:0]  sb_speed = 2'b01;
   logic [15:0] rx_cfg = '0;
   logic        rx_cfg_vld = 1'b0, rx_sync = 1'b1, rx_err = 1'b0, sts_clr = 1'b0;
   logic [15:0] tx_cfg, lp_page;
   logic        an_done, an_irq, lp_fdx, res_fdx;
   logic [1:0]  lp_speed;

   int n_chk = 0;
   int n_fail = 0;
   bit finished = 1'b0;

   always #(CLK_PER/2) clk = ~clk;

   an37_seq #(
      .AN_EN_RST(1'b1), .BRK_X_CYC(BRK_X), .BRK_S_CYC(BRK_S),
      .SYNC_X_CYC(SYN_X), .SYNC_S_CYC(SYN_S), .MATCH_N(3)
   ) u_dut (
      .clk(clk), .rst_n(rst_n), .sgmii_en(sgmii_en), .phy_side(phy_side),
      .pin_src(pin_src), .ctrl_wr(ctrl_wr), .ctrl_wdata(ctrl_wdata), .ctrl_q(ctrl_q),
      .adv_word(adv_word), .anc_link(anc_link), .anc_irq_en(anc_irq_en),
      .sb_link(sb_link), .sb_fdx(sb_fdx), .sb_speed(sb_speed),
      .rx_cfg(rx_cfg), .rx_cfg_vld(rx_cfg_vld), .rx_sync(rx_sync), .rx_err(rx_err),
      .sts_clr(sts_clr), .tx_cfg(tx_cfg), .an_done(an_done), .an_irq(an_irq),
      .lp_page(lp_page), .lp_fdx(lp_fdx), .lp_speed(lp_speed), .res_fdx(res_fdx)
   );

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic tick(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic wr_ctrl(input logic [15:0] v);
      @(negedge clk);
      ctrl_wr = 1'b1; ctrl_wdata = v;
      @(negedge clk);
      ctrl_wr = 1'b0;
   endtask

   task automatic send(input logic [15:0] w);
      @(negedge clk);
      rx_cfg = w; rx_cfg_vld = 1'b1;
      @(negedge clk);
      rx_cfg_vld = 1'b0;
   endtask

   task automatic send_n(input logic [15:0] w, input int n);
      for (int i = 0; i < n; i++) send(w);
   endtask

   task automatic pulse_clr();
      @(negedge clk); sts_clr = 1'b1;
      @(negedge clk); sts_clr = 1'b0;
   endtask

   task automatic wait_ability();
      for (int i = 0; i < 200 && tx_cfg == 16'h0; i++) @(negedge clk);
   endtask

   task automatic do_reset(input logic s, input logic p, input logic ps);
      @(negedge clk);
      rst_n = 1'b0; sgmii_en = s; phy_side = p; pin_src = ps;
      tick(3);
      rst_n = 1'b1;
   endtask

   task automatic measure_break(input int lim, input string req);
      int n = 0;
      for (int i = 0; i < 400; i++) begin
         @(negedge clk);
         if (tx_cfg != 16'h0) break;
         n++;
      end
      chk(n >= lim && n <= lim + 2, req, n, lim);
   endtask

   // R1 reset state, R3 silent length in 1000BASE-X, R5 word
   task automatic t_reset_x();
      do_reset(1'b0, 1'b0, 1'b0);
      @(negedge clk);
      chk(ctrl_q == 16'h1140, "R1 ctrl reset", ctrl_q, 16'h1140);
      chk(tx_cfg == 16'h0, "R2 silent after reset", tx_cfg, 0);
      chk(!an_done && !an_irq, "R10 status reset", {an_done, an_irq}, 0);
      measure_break(BRK_X - 1, "R3 silent length 1000BASE-X");
      chk(tx_cfg == 16'h01A0, "R5 ability word", tx_cfg, 16'h01A0);
   endtask

   // R8 matching, R9 ack phase and completion, R10, R11
   task automatic t_negotiate_x();
      send(16'h0020); send(16'h0000); send(16'h0020); send(16'h0020);
      tick(2);
      chk(tx_cfg == 16'h01A0, "R8 zero word clears count", tx_cfg, 16'h01A0);
      send(16'h4020);
      tick(2);
      chk(tx_cfg == 16'h41A0, "R9 ack sent after base page (R8 ack ignored)", tx_cfg, 16'h41A0);
      chk(!an_done, "R9 not done before ack phase", an_done, 0);
      send_n(16'h4020, 3);
      tick(2);
      chk(an_done && an_irq, "R10 done and irq", {an_done, an_irq}, 2'b11);
      chk(lp_page == 16'h0020, "R10 partner page", lp_page, 16'h0020);
      chk(res_fdx == 1'b1, "R11 full duplex resolved", res_fdx, 1);
      tick(5);
      chk(an_done, "R10 done sticky", an_done, 1);
      pulse_clr();
      tick(1);
      chk(!an_done && !an_irq, "R10 w1c clear", {an_done, an_irq}, 0);
   endtask

   // R13 partner new page, R11 half duplex, R10 irq gating
   task automatic t_repage_x();
      send(16'h0040);
      tick(1);
      chk(tx_cfg == 16'h0, "R13 new partner page restarts", tx_cfg, 0);
      wait_ability();
      anc_irq_en = 1'b0;
      send_n(16'h0040, 3);
      send_n(16'h4040, 3);
      tick(2);
      chk(an_done && !an_irq, "R10 irq gated by enable", {an_done, an_irq}, 2'b10);
      chk(res_fdx == 1'b0, "R11 half duplex resolved", res_fdx, 0);
      pulse_clr();
      anc_irq_en = 1'b1;
   endtask

   // R13 rx error, R4 sync loss
   task automatic t_err_sync(input int lim, input logic [15:0] word, input string req);
      if (lim == SYN_X) begin
         @(negedge clk); rx_err = 1'b1;
         @(negedge clk); rx_err = 1'b0;
         tick(1);
         chk(tx_cfg == 16'h0, "R13 rx error restarts", tx_cfg, 0);
         wait_ability();
      end
      @(negedge clk); rx_sync = 1'b0;
      tick(lim - 2);
      rx_sync = 1'b1;
      tick(2);
      chk(tx_cfg == word, {req, " short loss ignored"}, tx_cfg, word);
      @(negedge clk); rx_sync = 1'b0;
      tick(lim + 2);
      chk(tx_cfg == 16'h0, {req, " long loss restarts"}, tx_cfg, 0);
      rx_sync = 1'b1;
      wait_ability();
   endtask

   // R1/R2 restart bit, R12 disabled, R11 forced duplex, R1 soft reset
   task automatic t_ctrl();
      wr_ctrl(16'h1340);
      chk(ctrl_q == 16'h1140, "R1 restart bit self clears", ctrl_q, 16'h1140);
      chk(tx_cfg == 16'h0, "R2 restart bit restarts", tx_cfg, 0);
      wait_ability();
      wr_ctrl(16'h0100);
      tick(1);
      chk(tx_cfg == 16'h0, "R12 disabled silent", tx_cfg, 0);
      chk(res_fdx == 1'b1, "R11 forced full duplex", res_fdx, 1);
      send_n(16'h0020, 3); send_n(16'h4020, 3);
      tick(2);
      chk(!an_done, "R12 rx ignored when disabled", an_done, 0);
      wr_ctrl(16'h0000);
      chk(res_fdx == 1'b0, "R11 forced half duplex", res_fdx, 0);
      wr_ctrl(16'h8000);
      chk(ctrl_q == 16'h1140, "R1 soft reset restores", ctrl_q, 16'h1140);
      tick(1);
      chk(tx_cfg == 16'h0, "R2 enable restarts silent phase", tx_cfg, 0);
   endtask

   // R6 SGMII MAC side, R3 SGMII silent length, R10 partner fields
   task automatic t_sgmii_mac();
      do_reset(1'b1, 1'b0, 1'b0);
      measure_break(BRK_S - 1, "R3 silent length SGMII");
      chk(tx_cfg == 16'h4001, "R6 MAC side word", tx_cfg, 16'h4001);
      send_n(16'hD801, 3);
      send_n(16'hD801, 3);
      tick(2);
      chk(an_done, "R9 SGMII complete", an_done, 1);
      chk(lp_speed == 2'b10 && lp_fdx, "R10 partner speed/duplex", {lp_speed, lp_fdx}, 3'b101);
      chk(lp_page == 16'h9801, "R10 SGMII partner page", lp_page, 16'h9801);
      chk(res_fdx, "R11 SGMII duplex", res_fdx, 1);
   endtask

   // R7 PHY side sources, R4 SGMII sync threshold
   task automatic t_sgmii_phy();
      do_reset(1'b1, 1'b1, 1'b0);
      wait_ability();
      chk(tx_cfg == 16'hD801, "R7 register sourced word", tx_cfg, 16'hD801);
      pin_src = 1'b1;
      tick(1);
      chk(tx_cfg == 16'h4401, "R7 pin sourced word", tx_cfg, 16'h4401);
      t_err_sync(SYN_S, 16'h4401, "R4 SGMII");
   endtask

   initial begin
      t_reset_x();
      t_negotiate_x();
      t_repage_x();
      t_err_sync(SYN_X, 16'h01A0, "R4 1000BASE-X");
      t_ctrl();
      t_sgmii_mac();
      t_sgmii_phy();
      if (!finished) begin
         finished = 1'b1;
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin
      #(CLK_PER * 150000);
      if (!finished) begin
         finished = 1'b1;
         n_chk++; n_fail++;
         $display("FAIL watchdog actual=timeout expected=completion");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end
endmodule